// File: doc/BRIEF.md
# Conflict-free 2D banked shared memory

This block is a shared on-chip word store that four parallel data paths see as one 48 x 48 grid of 16-bit words. In a single cycle the four data paths reach the four corners of a 2x2 pattern together, for a read or for a write. A descriptor places the pattern: a base column h, a base row v, a column distance hd and a row distance vd. Lane 0 takes (h, v), lane 1 takes (h+hd, v), lane 2 takes (h, v+vd) and lane 3 takes (h+hd, v+vd).

The words are held in nine single-ported banks of 256 words each. A bank is picked from the residues of the column and row modulo 3, so any four corners whose distances are not multiples of 3 fall into four different banks. A crossbar routes write data and addresses to the banks, and routes the bank outputs back to the lanes. If a descriptor breaks the distance rule or reaches outside the grid, the access is dropped and an error pulse is raised. A separate single-word host write port fills the store for test.

Top module: `mm2d_mem`

## Requirements
- R1: While rst_ni is low, and after reset until the first request, rvalid_o and err_o are 0.
- R2: Word (x, y) is stored in bank (x mod 3) + 3*(y mod 3) at in-bank offset (y div 3)*16 + (x div 3). On every accepted access the four lanes use four different banks.
- R3: Lane k (k = 0..3) returns its word on rdata_o[16k+15:16k] and takes its write word from wdata_i[16k+15:16k]. The lane order is (h,v), (h+hd,v), (h,v+vd), (h+hd,v+vd).
- R4: For an accepted read, rvalid_o is 1 and rdata_o holds the four words in the clock cycle that follows the request. In every other cycle rvalid_o is 0.
- R5: An accepted write stores all four lane words in the same cycle and does not raise rvalid_o.
- R6: When hd or vd is a multiple of 3 (0 included), err_o is 1 in the following cycle, memory is not changed and rvalid_o stays 0.
- R7: When any of the four coordinates is 48 or greater, err_o is 1 in the following cycle and the access is dropped in the same way as in R6.
- R8: When req_i is low and (host_x_i, host_y_i) is inside the grid, a pulse on host_we_i writes host_wdata_i to that word. The host write is ignored while req_i is high and ignored when the coordinate is outside the grid.
- R9: Any base coordinate works, up to patterns whose corners touch column 47 and row 47.
- R10: rdata_o keeps the last read result until the next accepted read, even when writes happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for all four lanes |
| we_i | input | 1 | 1 = write, 0 = read |
| h_i | input | 6 | Base column |
| v_i | input | 6 | Base row |
| hd_i | input | 6 | Column distance |
| vd_i | input | 6 | Row distance |
| wdata_i | input | 64 | Lane write words, lane k at bits 16k+15:16k |
| host_we_i | input | 1 | Host single-word write strobe |
| host_x_i | input | 6 | Host write column |
| host_y_i | input | 6 | Host write row |
| host_wdata_i | input | 16 | Host write word |
| rdata_o | output | 64 | Lane read words, lane k at bits 16k+15:16k |
| rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| err_o | output | 1 | Rejected access flag, one cycle after the request |

## Verification
The hardest case to reach from the ports is a wrong bank or offset mapping. Such a mapping can still return correct data when the bench only reads back what it just wrote through the same 2x2 path. To expose it, the whole grid is first loaded one word at a time through the host port, each word with a value unique to its coordinate. The 2x2 reads then have to find those values through a completely different route into the banks. An out-of-range host write is aimed at a coordinate whose truncated address would overwrite a real word, and that word is read back afterwards. Rejected writes are always followed by reads of the same corners.

// File: rtl/mm2d_pkg.sv
package mm2d_pkg;
  localparam int FOLD  = 3;  // residue classes per axis
  localparam int LANES = 4;  // 2x2 pattern
endpackage

// File: rtl/mm2d_addr_map.sv
module mm2d_addr_map
  import mm2d_pkg::*;
#(
  parameter int GRID = 48,
  parameter int CW   = 6,
  parameter int BIW  = 4,
  parameter int BAW  = 8
) (
  input  logic [CW:0]    x_i,
  input  logic [CW:0]    y_i,
  output logic [BIW-1:0] bank_o,
  output logic [BAW-1:0] addr_o,
  output logic           in_range_o
);
  localparam int ROW_W = GRID / FOLD;

  int xi, yi;

  always_comb begin
    xi         = int'(x_i);
    yi         = int'(y_i);
    in_range_o = (xi < GRID) && (yi < GRID);
    bank_o     = BIW'((xi % FOLD) + FOLD * (yi % FOLD));
    addr_o     = BAW'((yi / FOLD) * ROW_W + (xi / FOLD));
  end
endmodule

// File: rtl/mm2d_bank.sv
module mm2d_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read port output only moves on a read, so it holds across writes
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/mm2d_xbar.sv
module mm2d_xbar
  import mm2d_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NBANK = 9,
  parameter int BIW   = 4,
  parameter int BAW   = 8
) (
  input  logic           acc_en_i,
  input  logic           acc_we_i,
  input  logic [BIW-1:0] lane_bank_i  [LANES],
  input  logic [BAW-1:0] lane_addr_i  [LANES],
  input  logic [DW-1:0]  lane_wdata_i [LANES],
  input  logic           host_en_i,
  input  logic [BIW-1:0] host_bank_i,
  input  logic [BAW-1:0] host_addr_i,
  input  logic [DW-1:0]  host_wdata_i,
  output logic           bank_en_o    [NBANK],
  output logic           bank_we_o    [NBANK],
  output logic [BAW-1:0] bank_addr_o  [NBANK],
  output logic [DW-1:0]  bank_wdata_o [NBANK],
  input  logic [BIW-1:0] sel_i        [LANES],
  input  logic [DW-1:0]  bank_q_i     [NBANK],
  output logic [DW-1:0]  lane_q_o     [LANES]
);
  // bank side: lanes hit distinct banks, host only runs without a request
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      bank_en_o[b]    = 1'b0;
      bank_we_o[b]    = 1'b0;
      bank_addr_o[b]  = host_addr_i;
      bank_wdata_o[b] = host_wdata_i;
      if (host_en_i && host_bank_i == BIW'(b)) begin
        bank_en_o[b] = 1'b1;
        bank_we_o[b] = 1'b1;
      end
      for (int l = 0; l < LANES; l++) begin
        if (acc_en_i && lane_bank_i[l] == BIW'(b)) begin
          bank_en_o[b]    = 1'b1;
          bank_we_o[b]    = acc_we_i;
          bank_addr_o[b]  = lane_addr_i[l];
          bank_wdata_o[b] = lane_wdata_i[l];
        end
      end
    end
  end

  // lane side: registered select picks the registered bank output
  always_comb begin
    for (int l = 0; l < LANES; l++) lane_q_o[l] = bank_q_i[sel_i[l]];
  end
endmodule

// File: rtl/mm2d_mem.sv
module mm2d_mem
  import mm2d_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GRID   = 48,
  parameter int CW     = $clog2(GRID)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [CW-1:0]           h_i,
  input  logic [CW-1:0]           v_i,
  input  logic [CW-1:0]           hd_i,
  input  logic [CW-1:0]           vd_i,
  input  logic [LANES*DATA_W-1:0] wdata_i,
  input  logic                    host_we_i,
  input  logic [CW-1:0]           host_x_i,
  input  logic [CW-1:0]           host_y_i,
  input  logic [DATA_W-1:0]       host_wdata_i,
  output logic [LANES*DATA_W-1:0] rdata_o,
  output logic                    rvalid_o,
  output logic                    err_o
);
  localparam int ROW_W = GRID / FOLD;
  localparam int DEPTH = ROW_W * ROW_W;
  localparam int BAW   = $clog2(DEPTH);
  localparam int NBANK = FOLD * FOLD;
  localparam int BIW   = $clog2(NBANK);

  logic [CW:0]       x_lo, x_hi, y_lo, y_hi;
  logic [CW:0]       lane_x     [LANES];
  logic [CW:0]       lane_y     [LANES];
  logic [BIW-1:0]    lane_bank  [LANES];
  logic [BAW-1:0]    lane_addr  [LANES];
  logic [DATA_W-1:0] lane_wdata [LANES];
  logic [DATA_W-1:0] lane_q     [LANES];
  logic [LANES-1:0]  lane_ok;
  logic [BIW-1:0]    sel_q      [LANES];

  logic              bank_en    [NBANK];
  logic              bank_we    [NBANK];
  logic [BAW-1:0]    bank_addr  [NBANK];
  logic [DATA_W-1:0] bank_wdata [NBANK];
  logic [DATA_W-1:0] bank_q     [NBANK];

  logic [BIW-1:0]    host_bank;
  logic [BAW-1:0]    host_addr;
  logic              host_in, host_ok;
  logic              stride_ok, acc_ok, acc_bad;
  logic              rvalid_q, err_q;

  assign x_lo = {1'b0, h_i};
  assign y_lo = {1'b0, v_i};
  assign x_hi = x_lo + {1'b0, hd_i};
  assign y_hi = y_lo + {1'b0, vd_i};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_x[l]     = (l % 2 == 1) ? x_hi : x_lo;
    assign lane_y[l]     = (l / 2 == 1) ? y_hi : y_lo;
    assign lane_wdata[l] = wdata_i[l*DATA_W +: DATA_W];
    assign rdata_o[l*DATA_W +: DATA_W] = lane_q[l];

    mm2d_addr_map #(
      .GRID(GRID), .CW(CW), .BIW(BIW), .BAW(BAW)
    ) u_map (
      .x_i       (lane_x[l]),
      .y_i       (lane_y[l]),
      .bank_o    (lane_bank[l]),
      .addr_o    (lane_addr[l]),
      .in_range_o(lane_ok[l])
    );
  end

  mm2d_addr_map #(
    .GRID(GRID), .CW(CW), .BIW(BIW), .BAW(BAW)
  ) u_host_map (
    .x_i       ({1'b0, host_x_i}),
    .y_i       ({1'b0, host_y_i}),
    .bank_o    (host_bank),
    .addr_o    (host_addr),
    .in_range_o(host_in)
  );

  // distances off the residue grid guarantee four distinct banks
  always_comb begin
    stride_ok = ((int'(hd_i) % FOLD) != 0) && ((int'(vd_i) % FOLD) != 0);
    acc_ok    = req_i && stride_ok && (&lane_ok);
    acc_bad   = req_i && !acc_ok;
    host_ok   = host_we_i && !req_i && host_in;
  end

  mm2d_xbar #(
    .DW(DATA_W), .NBANK(NBANK), .BIW(BIW), .BAW(BAW)
  ) u_xbar (
    .acc_en_i    (acc_ok),
    .acc_we_i    (we_i),
    .lane_bank_i (lane_bank),
    .lane_addr_i (lane_addr),
    .lane_wdata_i(lane_wdata),
    .host_en_i   (host_ok),
    .host_bank_i (host_bank),
    .host_addr_i (host_addr),
    .host_wdata_i(host_wdata_i),
    .bank_en_o   (bank_en),
    .bank_we_o   (bank_we),
    .bank_addr_o (bank_addr),
    .bank_wdata_o(bank_wdata),
    .sel_i       (sel_q),
    .bank_q_i    (bank_q),
    .lane_q_o    (lane_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    mm2d_bank #(
      .DW(DATA_W), .DEPTH(DEPTH), .AW(BAW)
    ) u_bank (
      .clk_i  (clk_i),
      .en_i   (bank_en[b]),
      .we_i   (bank_we[b]),
      .addr_i (bank_addr[b]),
      .wdata_i(bank_wdata[b]),
      .rdata_o(bank_q[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      for (int l = 0; l < LANES; l++) sel_q[l] <= '0;
    end else begin
      rvalid_q <= acc_ok && !we_i;
      err_q    <= acc_bad;
      if (acc_ok && !we_i) begin
        for (int l = 0; l < LANES; l++) sel_q[l] <= lane_bank[l];
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/mm2d_chk.sv
module mm2d_chk
  import mm2d_pkg::*;
#(
  parameter int CW    = 6,
  parameter int BIW   = 4,
  parameter int NBANK = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic [CW-1:0]  hd_i,
  input logic [CW-1:0]  vd_i,
  input logic           acc_ok_i,
  input logic           rvalid_i,
  input logic           err_i,
  input logic [BIW-1:0] lane_bank_i [LANES],
  input logic           bank_en_i   [NBANK]
);
  logic [NBANK-1:0] en_vec;
  logic             dup;

  always_comb begin
    for (int b = 0; b < NBANK; b++) en_vec[b] = bank_en_i[b];
    dup = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (lane_bank_i[i] == lane_bank_i[j]) dup = 1'b1;
  end

  AST_LANES_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok_i |-> !dup); // R2
  AST_FOUR_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok_i |-> $countones(en_vec) == LANES); // R2
  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok_i && !we_i) |=> (rvalid_i && !err_i)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rvalid_i && !err_i)); // R4
  AST_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rvalid_i); // R5
  AST_BAD_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ((hd_i % 3) == 0 || (vd_i % 3) == 0)) |=> (err_i && !rvalid_i)); // R6
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !rvalid_i); // R7
endmodule

bind mm2d_mem mm2d_chk #(
  .CW(CW), .BIW(BIW), .NBANK(NBANK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .hd_i       (hd_i),
  .vd_i       (vd_i),
  .acc_ok_i   (acc_ok),
  .rvalid_i   (rvalid_o),
  .err_i      (err_o),
  .lane_bank_i(lane_bank),
  .bank_en_i  (bank_en)
);

// File: tb/sim_mm2d_mem.sv
`timescale 1ns/1ps
module sim_mm2d_mem;
  localparam int G = 48;
  localparam int NV = 17;
  // {exp_err, we, h, v, hd, vd}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd0,  6'd0,  6'd1,  6'd1},
    {1'b0, 1'b0, 6'd10, 6'd20, 6'd2,  6'd4},
    {1'b0, 1'b1, 6'd5,  6'd7,  6'd1,  6'd2},
    {1'b0, 1'b0, 6'd5,  6'd7,  6'd1,  6'd2},
    {1'b0, 1'b0, 6'd46, 6'd46, 6'd1,  6'd1},
    {1'b1, 1'b0, 6'd47, 6'd0,  6'd1,  6'd1},
    {1'b1, 1'b0, 6'd3,  6'd3,  6'd3,  6'd1},
    {1'b1, 1'b0, 6'd3,  6'd3,  6'd1,  6'd6},
    {1'b0, 1'b1, 6'd40, 6'd40, 6'd5,  6'd7},
    {1'b0, 1'b0, 6'd40, 6'd40, 6'd5,  6'd7},
    {1'b1, 1'b1, 6'd46, 6'd46, 6'd2,  6'd1},
    {1'b0, 1'b0, 6'd46, 6'd46, 6'd1,  6'd1},
    {1'b1, 1'b1, 6'd0,  6'd0,  6'd3,  6'd3},
    {1'b0, 1'b0, 6'd0,  6'd0,  6'd1,  6'd1},
    {1'b0, 1'b0, 6'd20, 6'd30, 6'd25, 6'd17},
    {1'b1, 1'b0, 6'd8,  6'd8,  6'd0,  6'd1},
    {1'b1, 1'b0, 6'd50, 6'd1,  6'd1,  6'd1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  h_i = '0, v_i = '0, hd_i = '0, vd_i = '0;
  logic [63:0] wdata_i = '0;
  logic        host_we_i = 1'b0;
  logic [5:0]  host_x_i = '0, host_y_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic [63:0] rdata_o;
  logic        rvalid_o, err_o;

  logic [15:0] ref_mem [G*G];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mm2d_mem u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // called at a negedge; returns at a negedge with inputs released
  task automatic host_wr(input int x, input int y, input logic [15:0] d);
    host_we_i = 1'b1; host_x_i = 6'(x); host_y_i = 6'(y); host_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    host_we_i = 1'b0;
    if (x < G && y < G) ref_mem[y*G + x] = d;
  endtask

  task automatic run_acc(input logic we, input int h, input int v, input int hd, input int vd,
                         input logic [63:0] wd, input logic exp_err);
    int xs[4], ys[4];
    logic [63:0] exp;
    xs = '{h, h + hd, h, h + hd};
    ys = '{v, v, v + vd, v + vd};
    req_i = 1'b1; we_i = we; h_i = 6'(h); v_i = 6'(v); hd_i = 6'(hd); vd_i = 6'(vd); wdata_i = wd;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk("R6 R7 err_o", {63'd0, err_o}, {63'd0, exp_err});
    chk("R4 R5 rvalid_o", {63'd0, rvalid_o}, {63'd0, (!we && !exp_err)});
    if (!exp_err) begin
      if (we) begin
        for (int k = 0; k < 4; k++) ref_mem[ys[k]*G + xs[k]] = wd[k*16 +: 16];
      end else begin
        for (int k = 0; k < 4; k++) exp[k*16 +: 16] = ref_mem[ys[k]*G + xs[k]];
        chk("R3 R9 rdata_o", rdata_o, exp);
      end
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    logic [63:0] wd;
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {62'd0, rvalid_o, err_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {62'd0, rvalid_o, err_o}, 64'd0);

    // R2 R8: fill every word through the host port, unique per coordinate
    for (int y = 0; y < G; y++)
      for (int x = 0; x < G; x++)
        host_wr(x, y, 16'((y * G + x) ^ 16'h3C00));

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 4; k++) wd[k*16 +: 16] = 16'(16'hA000 + i * 16 + k);
      run_acc(VEC[i][24], int'(VEC[i][23:18]), int'(VEC[i][17:12]),
              int'(VEC[i][11:6]), int'(VEC[i][5:0]), wd, VEC[i][25]);
    end

    // R4: single pulse
    @(posedge clk_i); @(negedge clk_i);
    chk("R4 rvalid_o idle", {63'd0, rvalid_o}, 64'd0);

    // R10: read result holds over a lane write and a host write
    run_acc(1'b0, 11, 13, 1, 2, 64'd0, 1'b0);
    held = rdata_o;
    run_acc(1'b1, 11, 13, 1, 2, 64'h1111_2222_3333_4444, 1'b0);
    host_wr(11, 13, 16'h7777);
    chk("R10 rdata_o hold", rdata_o, held);
    run_acc(1'b0, 11, 13, 1, 2, 64'd0, 1'b0);

    // R8: host write during a request is ignored
    req_i = 1'b1; we_i = 1'b0; h_i = 6'd1; v_i = 6'd1; hd_i = 6'd1; vd_i = 6'd1;
    host_we_i = 1'b1; host_x_i = 6'd1; host_y_i = 6'd1; host_wdata_i = 16'hDEAD;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0; host_we_i = 1'b0;
    run_acc(1'b0, 1, 1, 1, 1, 64'd0, 1'b0);
    chk("R8 host ignored under req", {48'd0, rdata_o[15:0]}, {48'd0, ref_mem[1*G + 1]});

    // R8: out-of-range host write must not alias onto (2,5)
    host_wr(50, 2, 16'hBEEF);
    run_acc(1'b0, 2, 5, 1, 1, 64'd0, 1'b0);
    chk("R8 host out of range", {48'd0, rdata_o[15:0]}, {48'd0, ref_mem[5*G + 2]});

    // R8: in-range host write lands
    host_wr(7, 8, 16'h1234);
    run_acc(1'b0, 7, 8, 2, 2, 64'd0, 1'b0);
    chk("R8 host write", {48'd0, rdata_o[15:0]}, 64'h1234);

    finish_run();
  end
endmodule